// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects fourteen peripheral interrupt sources and presents one 3-bit priority code to a processor. It keeps two registers: a request register that records which sources are pending, and an enable register that chooses which sources may interrupt. The enable register also holds a master enable that can silence every source at once. A pending and enabled source belongs to one of six fixed levels, and the block reports the highest such level on a registered output. Level 7 is never produced. It stays free for a non-maskable input outside this block.

Software reaches both registers over a small word bus. Each register has a write port and a separate read-only status port. Bit 15 of every written word selects the operation: when it is set, the other 1 bits of the word are set in the register; when it is clear, they are cleared. Bits written as 0 keep their value. Peripherals raise requests with one-cycle pulses. Two external timer/port controllers have their own request lines. Software can also raise any request bit itself, and the software interrupt is raised this way.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `bus_addr` selects the port: 0 writes the enable register, 1 writes the request register, 2 reads the enable register and 3 reads the request register. `bus_rdata` follows the address and the register contents in the same cycle. It reads 0 on addresses 0 and 1, and it always reads 0 in bit 15 and in request bit 14.
- R2: Enable bit 14 is the master enable. While it is clear, `irq_level` is 0 one clock later, whatever is pending.
- R3: Request and enable bits group into levels as follows: bits 0, 1 and 2 form level 1; bit 3 forms level 2; bits 4, 5 and 6 form level 3; bits 7 to 10 form level 4; bits 11 and 12 form level 5; bit 13 forms level 6.
- R4: `irq_level` is registered. At each clock edge it takes the highest level that has at least one bit both pending and enabled, with the master enable set, in the state before that edge. It is 0 when no bit qualifies.
- R5: A write with `bus_wdata[15]`=1 sets every register bit whose data bit is 1 and leaves the other bits unchanged.
- R6: A write with `bus_wdata[15]`=0 clears every register bit whose data bit is 1 and leaves the other bits unchanged. For example, writing 16'h0020 to address 1 clears the vertical-blank request, bit 5.
- R7: A pulse on `dev_pulse[i]` sets request bit i at the next clock edge. `ext_lo_irq` sets request bit 3 and `ext_hi_irq` sets request bit 13 in the same way.
- R8: When a source pulse and a clearing write hit the same request bit in the same cycle, the bit ends up set.
- R9: `irq_level` never takes the value 7.
- R10: Software raises the software interrupt by writing 16'h8004 to address 1. This sets request bit 2, which gives level 1 when bit 2 and the master enable are enabled.
- R11: After reset both registers are 0 and `irq_level` is 0.
- R12: A write strobe on address 2 or 3 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_addr | input | 2 | Port select: enable write, request write, enable status, request status |
| bus_wdata | input | 16 | Write word, with bit 15 selecting set (1) or clear (0) |
| bus_rdata | output | 16 | Status word of the addressed read port |
| dev_pulse | input | 14 | One-cycle request pulses, bit i raises request i |
| ext_lo_irq | input | 1 | Low external controller request, raises bit 3 |
| ext_hi_irq | input | 1 | High external controller request, raises bit 13 |
| irq_level | output | 3 | Registered priority level for the processor, 0 when none |

## Verification
The priority encoder is driven with single pending bits on each level, and then with mixed sets where a lower level is pending next to a higher one. This separates a wrong level grouping from a wrong priority order. Set and clear writes are made on words with neighbouring bits already set, so an operation that touches unnamed bits shows up at the status ports. Pulses that coincide with clearing writes show whether the hardware set wins. A master-off phase with many bits pending shows whether the master gate works. A long stretch of mixed pulses and writes, compared every clock against a behavioural model, covers the interaction between the two registers and the one-cycle lag of the level output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC  = 14;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int LVL_W    = 3;
  localparam int NUM_LVL  = 6;
  localparam int ENA_W    = NUM_SRC + 1;      // sources plus master enable
  localparam int MASTER_B = NUM_SRC;          // master enable position
  localparam int OP_B     = DATA_W - 1;       // set/clear selector bit
  localparam int EXT_LO_B = 3;
  localparam int EXT_HI_B = 13;

  typedef enum logic [ADDR_W-1:0] {
    PORT_ENA_WR  = 2'd0,
    PORT_REQ_WR  = 2'd1,
    PORT_ENA_RD  = 2'd2,
    PORT_REQ_RD  = 2'd3
  } port_e;

  // Level carried by a request bit (fixed grouping).
  function automatic int unsigned level_of_bit(int unsigned b);
    if (b <= 2)       return 1;
    else if (b == 3)  return 2;
    else if (b <= 6)  return 3;
    else if (b <= 10) return 4;
    else if (b <= 12) return 5;
    else              return 6;
  endfunction

  // Mask of request bits belonging to one level.
  function automatic logic [NUM_SRC-1:0] level_mask(int unsigned lvl);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < NUM_SRC; b++)
      if (level_of_bit(b) == lvl) m[b] = 1'b1;
    return m;
  endfunction

  // Set/clear update of a register from a write word.
  function automatic logic [DATA_W-2:0] apply_write(logic [DATA_W-2:0] cur,
                                                    logic [DATA_W-2:0] bits,
                                                    logic op_set);
    return op_set ? (cur | bits) : (cur & ~bits);
  endfunction
endpackage

// File: rtl/irqc_sc_reg.sv
module irqc_sc_reg
  import irqc_pkg::*;
#(
  parameter int W = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         op_set,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  localparam int PADW = (DATA_W - 1) - W;

  logic [W-1:0] sw_next;
  logic [DATA_W-2:0] wide_cur, wide_bits, wide_res;

  assign wide_cur  = {{PADW{1'b0}}, q};
  assign wide_bits = {{PADW{1'b0}}, wbits};
  assign wide_res  = apply_write(wide_cur, wide_bits, op_set);

  always_comb begin
    sw_next = wr_en ? wide_res[W-1:0] : q;
  end

  // hardware set is ORed last, so it wins over a same-cycle clear (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next | hw_set;
  end

  a_r5_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_set) |=> ((q & $past(wbits)) == $past(wbits)));

  a_r6_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !op_set && ((wbits & hw_set) == '0)) |=> ((q & $past(wbits)) == '0));

  a_r8_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] enables,
  input  logic               master,
  output logic [LVL_W-1:0]   level
);
  logic [NUM_SRC-1:0] qualified;
  logic [NUM_LVL:1]   lvl_hit;
  logic [LVL_W-1:0]   lvl_next;

  assign qualified = master ? (pending & enables) : '0;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    assign lvl_hit[l] = |(qualified & level_mask(l));
  end

  always_comb begin
    lvl_next = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (lvl_hit[l]) lvl_next = LVL_W'(l);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= lvl_next;
  end

  a_r2_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> (level == '0));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & enables) == '0) |=> (level == '0));

  a_r9_never_seven: assert property (@(posedge clk) disable iff (!rst_n)
    level != 3'd7);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] dev_pulse,
  input  logic               ext_lo_irq,
  input  logic               ext_hi_irq,
  output logic [LVL_W-1:0]   irq_level
);
  logic               ena_we, req_we, op_set;
  logic [ENA_W-1:0]   ena_q;
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] ext_set;

  assign ena_we = bus_wr && (bus_addr == PORT_ENA_WR);
  assign req_we = bus_wr && (bus_addr == PORT_REQ_WR);
  assign op_set = bus_wdata[OP_B];

  always_comb begin
    ext_set = '0;
    ext_set[EXT_LO_B] = ext_lo_irq;
    ext_set[EXT_HI_B] = ext_hi_irq;
  end
  assign hw_set = dev_pulse | ext_set;

  irqc_sc_reg #(.W(ENA_W)) u_ena (
    .clk(clk), .rst_n(rst_n), .wr_en(ena_we), .op_set(op_set),
    .wbits(bus_wdata[ENA_W-1:0]), .hw_set({ENA_W{1'b0}}), .q(ena_q)
  );

  irqc_sc_reg #(.W(NUM_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(req_we), .op_set(op_set),
    .wbits(bus_wdata[NUM_SRC-1:0]), .hw_set(hw_set), .q(req_q)
  );

  irqc_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n), .pending(req_q),
    .enables(ena_q[NUM_SRC-1:0]), .master(ena_q[MASTER_B]), .level(irq_level)
  );

  always_comb begin
    unique case (bus_addr)
      PORT_ENA_RD: bus_rdata = {{(DATA_W-ENA_W){1'b0}}, ena_q};
      PORT_REQ_RD: bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, req_q};
      default:     bus_rdata = '0;
    endcase
  end

  a_r12_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1] && (hw_set == '0)) |=> ($stable(ena_q) && $stable(req_q)));

  a_r7_ext_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hi_irq |=> req_q[EXT_HI_B]);

  a_r7_ext_lo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_lo_irq |=> req_q[EXT_LO_B]);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [13:0] dev_pulse = '0;
  logic        ext_lo_irq = 1'b0;
  logic        ext_hi_irq = 1'b0;
  logic [2:0]  irq_level;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] ena_m, req_m;
  int lvl_m;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_pulse(dev_pulse),
    .ext_lo_irq(ext_lo_irq), .ext_hi_irq(ext_hi_irq), .irq_level(irq_level)
  );

  function automatic int lvl_ref(logic [15:0] m);
    if (m[13])             return 6;
    if (m[12] || m[11])    return 5;
    if ((m & 16'h0780) != 0) return 4;
    if ((m & 16'h0070) != 0) return 3;
    if (m[3])              return 2;
    if ((m & 16'h0007) != 0) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: model update at the edge, comparison at the falling edge.
  task automatic tick();
    logic [15:0] hw, w, masked;
    int nl;
    @(posedge clk);
    if (!rst_n) begin
      ena_m = 0; req_m = 0; lvl_m = 0;
    end else begin
      masked = ena_m[14] ? (req_m & ena_m & 16'h3FFF) : 16'h0;
      nl = lvl_ref(masked);
      hw = {2'b0, dev_pulse} | (16'(ext_lo_irq) << 3) | (16'(ext_hi_irq) << 13);
      if (bus_wr && bus_addr == 2'd0) begin
        w = bus_wdata & 16'h7FFF;
        ena_m = bus_wdata[15] ? (ena_m | w) : (ena_m & ~w);
      end
      if (bus_wr && bus_addr == 2'd1) begin
        w = bus_wdata & 16'h3FFF;
        req_m = bus_wdata[15] ? (req_m | w) : (req_m & ~w);
      end
      req_m = req_m | hw;
      lvl_m = nl;
    end
    @(negedge clk);
    chk("R4 level vs model", int'(irq_level), lvl_m);
    chk("R9 level not 7", int'(irq_level == 3'd7), 0);
    chk("R1 rdata vs model", int'(bus_rdata),
        bus_addr == 2'd2 ? int'(ena_m) : bus_addr == 2'd3 ? int'(req_m) : 0);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
  endtask

  task automatic pulse(logic [13:0] p, logic lo, logic hi);
    dev_pulse = p; ext_lo_irq = lo; ext_hi_irq = hi;
    tick();
    dev_pulse = '0; ext_lo_irq = 1'b0; ext_hi_irq = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, string tag, int exp);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    ena_m = 0; req_m = 0; lvl_m = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11 level after reset", int'(irq_level), 0);
    peek(2'd2, "R11 enable after reset", 0);
    peek(2'd3, "R11 request after reset", 0);

    // R5 set master + vblank enable
    wr(2'd0, 16'hC020);
    peek(2'd2, "R5 enable set write", 16'h4020);
    peek(2'd0, "R1 write address reads zero", 0);

    // R7 vblank pulse -> level 3 (R3)
    pulse(14'h0020, 1'b0, 1'b0);
    peek(2'd3, "R7 pulse sets request", 16'h0020);
    tick();
    chk("R3 vblank gives level 3", int'(irq_level), 3);

    // R6 clear vblank request
    wr(2'd1, 16'h0020);
    peek(2'd3, "R6 clear write", 16'h0000);
    tick();
    chk("R6 level drops after clear", int'(irq_level), 0);

    // R2 master off
    wr(2'd0, 16'h4000);
    pulse(14'h0020, 1'b0, 1'b0);
    tick(); tick();
    chk("R2 master clear gates level", int'(irq_level), 0);
    wr(2'd0, 16'hC000);
    tick();
    chk("R2 master set restores level", int'(irq_level), 3);

    // enable everything; R5 does not touch bit 15
    wr(2'd0, 16'hFFFF);
    peek(2'd2, "R1 enable bit15 reads zero", 16'h7FFF);
    wr(2'd1, 16'h3FFF);
    pulse(14'h0000, 1'b0, 1'b1);
    peek(2'd3, "R7 high external sets bit 13", 16'h2000);
    tick();
    chk("R3 bit 13 gives level 6", int'(irq_level), 6);
    wr(2'd1, 16'h2000);
    pulse(14'h0000, 1'b1, 1'b0);
    peek(2'd3, "R7 low external sets bit 3", 16'h0008);
    tick();
    chk("R3 bit 3 gives level 2", int'(irq_level), 2);

    // R4 priority among mixed levels
    wr(2'd1, 16'h8881);
    peek(2'd3, "R5 request set keeps bit 3", 16'h0889);
    tick();
    chk("R4 highest of 0,3,7,11 is 5", int'(irq_level), 5);
    wr(2'd1, 16'h0800);
    tick();
    chk("R4 highest of 0,3,7 is 4", int'(irq_level), 4);

    // R10 software interrupt
    wr(2'd1, 16'h3FFF);
    wr(2'd1, 16'h8004);
    peek(2'd3, "R10 software bit set", 16'h0004);
    tick();
    chk("R10 software interrupt level 1", int'(irq_level), 1);

    // R8 pulse wins over same-cycle clear
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0044; dev_pulse = 14'h0040;
    tick();
    bus_wr = 1'b0; dev_pulse = '0;
    peek(2'd3, "R8 set beats clear", 16'h0040);

    // R12 writes to status ports are inert
    wr(2'd2, 16'h7FFF);
    wr(2'd3, 16'hBFFF);
    peek(2'd2, "R12 enable unchanged", 16'h7FFF);
    peek(2'd3, "R12 request unchanged", 16'h0040);

    // Mixed traffic against the model (R4, R1)
    for (int i = 0; i < 400; i++) begin
      bus_addr = 2'($urandom_range(0, 3));
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_wdata = 16'($urandom);
      dev_pulse = ($urandom_range(0, 2) == 0) ? 14'(1 << $urandom_range(0, 13)) : 14'h0;
      ext_lo_irq = ($urandom_range(0, 15) == 0);
      ext_hi_irq = ($urandom_range(0, 15) == 0);
      tick();
    end
    bus_wr = 1'b0; dev_pulse = '0; ext_lo_irq = 1'b0; ext_hi_irq = 1'b0;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule